// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the 9-bit register-operand field of an instruction into a 12-bit data-space address. The two top bits of the field select one of four address shapes, and an all-zero field is a fifth case.

- **Zero field:** the address is read through a 16-bit indirect pointer.
- **Direct, special-purpose:** the low seven bits address the special-purpose register window at the bottom of data space.
- **Direct, global:** the low seven bits address the global register window, which starts at 0x080.
- **Offset through a pointer:** the low seven bits are an unsigned offset added to either the 16-bit data pointer or the 16-bit stack pointer.

Each pointer arrives as a high byte and a low byte.

The result is registered, so it appears one clock after the field and the pointers are applied. It comes with a 3-bit mode code and a range-error flag. The flag is raised in two cases:

- A pointer-based result falls outside the legal window.
- A special-purpose access targets one of the reserved lowest locations.

The address output always carries the low twelve bits of the computed value, even when the flag is raised.

Top module: `opnd_ea_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `eaOut` = 0, `modeOut` = 0 and `rangeErr` = 0.
- R2: A field of all zeros gives `modeOut` = 0 and `eaOut` equal to the low 12 bits of {ipPtrHi, ipPtrLo}.
- R3: A non-zero field with bits [8:7] = 00 gives `modeOut` = 1 and `eaOut` equal to bits [6:0] of the field.
- R4: Field bits [8:7] = 01 give `modeOut` = 2, `eaOut` = 0x080 + bits [6:0], and `rangeErr` = 0.
- R5: Field bits [8:7] = 10 give `modeOut` = 3 and `eaOut` equal to the low 12 bits of {dpPtrHi, dpPtrLo} + bits [6:0], with the offset zero-extended.
- R6: Field bits [8:7] = 11 give `modeOut` = 4 and `eaOut` equal to the low 12 bits of {spPtrHi, spPtrLo} + bits [6:0], with the offset zero-extended.
- R7: In modes 0, 3 and 4, `rangeErr` is 1 when the full unwrapped result exceeds 0xFFF. This includes a carry out of the 16-bit pointer.
- R8: In modes 0, 3 and 4, `rangeErr` is 1 when the full result is 0x020 or lower. It is 0 for results from 0x021 to 0xFFF.
- R9: In mode 1, `rangeErr` is 1 exactly when bits [6:0] are 0x002 or lower.
- R10: Every output reflects the field and pointer values sampled at the previous rising clock edge, and a new operand is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fieldIn | input | 9 | Operand field: bits [8:7] select the mode, bits [6:0] carry the address or offset |
| ipPtrHi | input | 8 | Indirect pointer, high byte |
| ipPtrLo | input | 8 | Indirect pointer, low byte |
| dpPtrHi | input | 8 | Data pointer, high byte |
| dpPtrLo | input | 8 | Data pointer, low byte |
| spPtrHi | input | 8 | Stack pointer, high byte |
| spPtrLo | input | 8 | Stack pointer, low byte |
| eaOut | output | 12 | Registered effective address |
| modeOut | output | 3 | Registered mode code: 0 indirect, 1 special, 2 global, 3 data pointer, 4 stack pointer |
| rangeErr | output | 1 | Registered range-error flag |

## Verification
The hardest cases to reach are the exact edges of the range check.

- **Pointer sum exactly 0xFFF:** must pass, while the same pointer plus one more offset step must fail.
- **Sum carrying out of sixteen bits:** the 12-bit address looks harmless, yet the flag must be raised.

Uniformly random pointers almost never land on these edges. The stimulus therefore drives directed pointer and offset pairs chosen so that the sum lands on each edge: 0x020, 0x021, 0xFFF, 0x1000, and a wrap past 0xFFFF. A random phase then draws pointers mostly from a narrow band around the legal window, with occasional full-range values.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [2:0] {
    MODE_IND = 3'd0,
    MODE_SPR = 3'd1,
    MODE_GLB = 3'd2,
    MODE_DPO = 3'd3,
    MODE_SPO = 3'd4
  } eaMode_e;

  typedef enum logic [1:0] {
    BASE_IP   = 2'd0,
    BASE_DP   = 2'd1,
    BASE_SP   = 2'd2,
    BASE_NONE = 2'd3
  } baseSel_e;

  typedef enum logic [1:0] {
    CHK_NONE = 2'd0,
    CHK_SPR  = 2'd1,
    CHK_PTR  = 2'd2
  } chkSel_e;

  typedef struct packed {
    baseSel_e baseSel;
    logic     addOffset;
    logic     addGlobal;
    chkSel_e  chkSel;
    eaMode_e  mode;
  } eaCtrl_t;

  localparam int PTR_IDX_IP = 0;
  localparam int PTR_IDX_DP = 1;
  localparam int PTR_IDX_SP = 2;
  localparam int NUM_PTR    = 3;

endpackage

// File: rtl/eagen_ctrl.sv
module eagen_ctrl
  import eagen_pkg::*;
#(
  parameter int FIELD_W = 9
) (
  input  logic [FIELD_W-1:0] fieldIn,
  output eaCtrl_t            ctrl
);

  localparam int SEL_HI = FIELD_W - 1;

  logic       fieldZero;
  logic [1:0] modeBits;

  assign fieldZero = (fieldIn == '0);
  assign modeBits  = fieldIn[SEL_HI -: 2];

  always_comb begin
    ctrl.baseSel   = BASE_NONE;
    ctrl.addOffset = 1'b0;
    ctrl.addGlobal = 1'b0;
    ctrl.chkSel    = CHK_NONE;
    ctrl.mode      = MODE_IND;
    if (fieldZero) begin
      ctrl.baseSel = BASE_IP;
      ctrl.chkSel  = CHK_PTR;
      ctrl.mode    = MODE_IND;
    end else begin
      unique case (modeBits)
        2'b00: begin
          ctrl.addOffset = 1'b1;
          ctrl.chkSel    = CHK_SPR;
          ctrl.mode      = MODE_SPR;
        end
        2'b01: begin
          ctrl.addOffset = 1'b1;
          ctrl.addGlobal = 1'b1;
          ctrl.mode      = MODE_GLB;
        end
        2'b10: begin
          ctrl.baseSel   = BASE_DP;
          ctrl.addOffset = 1'b1;
          ctrl.chkSel    = CHK_PTR;
          ctrl.mode      = MODE_DPO;
        end
        default: begin
          ctrl.baseSel   = BASE_SP;
          ctrl.addOffset = 1'b1;
          ctrl.chkSel    = CHK_PTR;
          ctrl.mode      = MODE_SPO;
        end
      endcase
    end
  end

endmodule

// File: rtl/eagen_dpath.sv
module eagen_dpath
  import eagen_pkg::*;
#(
  parameter int PTR_W         = 16,
  parameter int EA_W          = 12,
  parameter int OFS_W         = 7,
  parameter int GLOBAL_BASE   = 128,
  parameter int PTR_LOW_LIMIT = 32,
  parameter int SPR_LOW_LIMIT = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  eaCtrl_t                          ctrl,
  input  logic [OFS_W-1:0]                 offset,
  input  logic [NUM_PTR-1:0][PTR_W-1:0]    ptrVals,
  output logic [EA_W-1:0]                  eaQ,
  output logic [2:0]                       modeQ,
  output logic                             errQ
);

  localparam int             SUM_W  = PTR_W + 1;
  localparam logic [SUM_W-1:0] EA_MAX = SUM_W'((1 << EA_W) - 1);
  localparam logic [SUM_W-1:0] GLOB   = SUM_W'(GLOBAL_BASE);
  localparam logic [SUM_W-1:0] PTR_LO = SUM_W'(PTR_LOW_LIMIT);
  localparam logic [SUM_W-1:0] SPR_LO = SUM_W'(SPR_LOW_LIMIT);

  logic [SUM_W-1:0] baseVal;
  logic [SUM_W-1:0] offTerm;
  logic [SUM_W-1:0] globTerm;
  logic [SUM_W-1:0] sumVal;
  logic             overHi;
  logic             underPtr;
  logic             underSpr;
  logic             errNext;

  always_comb begin
    unique case (ctrl.baseSel)
      BASE_IP: baseVal = {1'b0, ptrVals[PTR_IDX_IP]};
      BASE_DP: baseVal = {1'b0, ptrVals[PTR_IDX_DP]};
      BASE_SP: baseVal = {1'b0, ptrVals[PTR_IDX_SP]};
      default: baseVal = '0;
    endcase
  end

  assign offTerm  = ctrl.addOffset ? SUM_W'(offset) : '0;
  assign globTerm = ctrl.addGlobal ? GLOB : '0;
  assign sumVal   = baseVal + offTerm + globTerm;

  assign overHi   = (sumVal > EA_MAX);
  assign underPtr = (sumVal <= PTR_LO);
  assign underSpr = (sumVal <= SPR_LO);

  always_comb begin
    unique case (ctrl.chkSel)
      CHK_PTR: errNext = overHi | underPtr;
      CHK_SPR: errNext = underSpr;
      default: errNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eaQ   <= '0;
      modeQ <= '0;
      errQ  <= 1'b0;
    end else begin
      eaQ   <= sumVal[EA_W-1:0];
      modeQ <= ctrl.mode;
      errQ  <= errNext;
    end
  end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import eagen_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int EA_W          = 12,
  parameter int OFS_W         = 7,
  parameter int GLOBAL_BASE   = 128,
  parameter int PTR_LOW_LIMIT = 32,
  parameter int SPR_LOW_LIMIT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OFS_W+1:0]     fieldIn,
  input  logic [BYTE_W-1:0]    ipPtrHi,
  input  logic [BYTE_W-1:0]    ipPtrLo,
  input  logic [BYTE_W-1:0]    dpPtrHi,
  input  logic [BYTE_W-1:0]    dpPtrLo,
  input  logic [BYTE_W-1:0]    spPtrHi,
  input  logic [BYTE_W-1:0]    spPtrLo,
  output logic [EA_W-1:0]      eaOut,
  output logic [2:0]           modeOut,
  output logic                 rangeErr
);

  localparam int FIELD_W = OFS_W + 2;
  localparam int PTR_W   = 2 * BYTE_W;

  logic [BYTE_W-1:0]                hiBytes [NUM_PTR];
  logic [BYTE_W-1:0]                loBytes [NUM_PTR];
  logic [NUM_PTR-1:0][PTR_W-1:0]    ptrVals;
  eaCtrl_t                          ctrl;

  assign hiBytes[PTR_IDX_IP] = ipPtrHi;
  assign loBytes[PTR_IDX_IP] = ipPtrLo;
  assign hiBytes[PTR_IDX_DP] = dpPtrHi;
  assign loBytes[PTR_IDX_DP] = dpPtrLo;
  assign hiBytes[PTR_IDX_SP] = spPtrHi;
  assign loBytes[PTR_IDX_SP] = spPtrLo;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    assign ptrVals[g] = {hiBytes[g], loBytes[g]};
  end

  eagen_ctrl #(
    .FIELD_W (FIELD_W)
  ) u_ctrl (
    .fieldIn (fieldIn),
    .ctrl    (ctrl)
  );

  eagen_dpath #(
    .PTR_W         (PTR_W),
    .EA_W          (EA_W),
    .OFS_W         (OFS_W),
    .GLOBAL_BASE   (GLOBAL_BASE),
    .PTR_LOW_LIMIT (PTR_LOW_LIMIT),
    .SPR_LOW_LIMIT (SPR_LOW_LIMIT)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .offset  (fieldIn[OFS_W-1:0]),
    .ptrVals (ptrVals),
    .eaQ     (eaOut),
    .modeQ   (modeOut),
    .errQ    (rangeErr)
  );

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk (
  input logic        clk,
  input logic        rst,
  input logic [8:0]  fieldIn,
  input logic [7:0]  dpPtrHi,
  input logic [7:0]  dpPtrLo,
  input logic [7:0]  spPtrHi,
  input logic [7:0]  spPtrLo,
  input logic [11:0] eaOut,
  input logic [2:0]  modeOut,
  input logic        rangeErr
);

  logic [15:0] dpSum;
  logic [15:0] spSum;
  assign dpSum = {dpPtrHi, dpPtrLo} + {9'd0, fieldIn[6:0]};
  assign spSum = {spPtrHi, spPtrLo} + {9'd0, fieldIn[6:0]};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (eaOut == 12'd0 && modeOut == 3'd0 && !rangeErr)); // R1

  AST_ZERO_FIELD_IND: assert property (@(posedge clk) disable iff (rst)
    (fieldIn == 9'd0) |=> (modeOut == 3'd0)); // R2

  AST_SPR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (modeOut == 3'd1) |-> (eaOut[11:7] == 5'd0)); // R3

  AST_GLOBAL_SAFE: assert property (@(posedge clk) disable iff (rst)
    (modeOut == 3'd2) |-> (eaOut[11:7] == 5'd1 && !rangeErr)); // R4

  AST_DP_SUM: assert property (@(posedge clk) disable iff (rst)
    (fieldIn[8:7] == 2'b10) |=> (modeOut == 3'd3 && eaOut == $past(dpSum[11:0]))); // R5

  AST_SP_SUM: assert property (@(posedge clk) disable iff (rst)
    (fieldIn[8:7] == 2'b11) |=> (modeOut == 3'd4 && eaOut == $past(spSum[11:0]))); // R6

  AST_SPR_GUARD: assert property (@(posedge clk) disable iff (rst)
    (modeOut == 3'd1) |-> (rangeErr == (eaOut <= 12'd2))); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (modeOut <= 3'd4)); // R10

endmodule

bind opnd_ea_gen eagen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .fieldIn  (fieldIn),
  .dpPtrHi  (dpPtrHi),
  .dpPtrLo  (dpPtrLo),
  .spPtrHi  (spPtrHi),
  .spPtrLo  (spPtrLo),
  .eaOut    (eaOut),
  .modeOut  (modeOut),
  .rangeErr (rangeErr)
);

// File: tb/tb_opnd_ea_gen.sv
module tb_opnd_ea_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  fieldIn = '0;
  logic [7:0]  ipPtrHi = '0, ipPtrLo = '0;
  logic [7:0]  dpPtrHi = '0, dpPtrLo = '0;
  logic [7:0]  spPtrHi = '0, spPtrLo = '0;
  logic [11:0] eaOut;
  logic [2:0]  modeOut;
  logic        rangeErr;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "";

  int    qEa[$];
  int    qMode[$];
  int    qErr[$];
  string qTag[$];

  always #2 clk = ~clk;

  opnd_ea_gen dut (
    .clk(clk), .rst(rst), .fieldIn(fieldIn),
    .ipPtrHi(ipPtrHi), .ipPtrLo(ipPtrLo),
    .dpPtrHi(dpPtrHi), .dpPtrLo(dpPtrLo),
    .spPtrHi(spPtrHi), .spPtrLo(spPtrLo),
    .eaOut(eaOut), .modeOut(modeOut), .rangeErr(rangeErr)
  );

  // Behavioural reference for one operand
  task automatic predict(input bit r, input int f, input int ip, input int dp,
                         input int sp, output int e, output int m, output int er,
                         output string tag);
    int n;
    int full;
    n = f % 128;
    if (r) begin
      e = 0; m = 0; er = 0; tag = "R1";
      return;
    end
    if (f == 0)        begin m = 0; full = ip; end
    else if (f < 128)  begin m = 1; full = n; end
    else if (f < 256)  begin m = 2; full = 128 + n; end
    else if (f < 384)  begin m = 3; full = dp + n; end
    else               begin m = 4; full = sp + n; end
    e = full % 4096;
    if (m == 1) begin
      er = (n <= 2) ? 1 : 0;
      tag = er ? "R9" : "R3";
    end else if (m == 2) begin
      er = 0; tag = "R4";
    end else if (full > 4095) begin
      er = 1; tag = "R7";
    end else if (full <= 32) begin
      er = 1; tag = "R8";
    end else begin
      er = 0;
      tag = (m == 0) ? "R2" : (m == 3) ? "R5" : "R6";
    end
  endtask

  task automatic checkFront();
    int e, m, er;
    string tag;
    if (qEa.size() == 0) return;
    e = qEa.pop_front(); m = qMode.pop_front();
    er = qErr.pop_front(); tag = qTag.pop_front();
    checks++;
    if (eaOut !== 12'(e) || modeOut !== 3'(m) || rangeErr !== 1'(er)) begin
      fails++;
      $display("FAIL %s%s: ea=%h mode=%0d err=%b expected ea=%h mode=%0d err=%0d",
               phase, tag, eaOut, modeOut, rangeErr, e, m, er);
    end
  endtask

  task automatic step(input bit r, input int f, input int ip, input int dp, input int sp);
    int e, m, er;
    string tag;
    @(negedge clk);
    checkFront();
    rst = r;
    fieldIn = 9'(f);
    {ipPtrHi, ipPtrLo} = 16'(ip);
    {dpPtrHi, dpPtrLo} = 16'(dp);
    {spPtrHi, spPtrLo} = 16'(sp);
    predict(r, f, ip, dp, sp, e, m, er, tag);
    qEa.push_back(e); qMode.push_back(m); qErr.push_back(er); qTag.push_back(tag);
  endtask

  function automatic int pickPtr();
    int sel;
    sel = int'($urandom_range(0, 9));
    if (sel < 7) return int'($urandom_range(0, 16'h1080));
    if (sel < 9) return int'($urandom_range(16'hFF80, 16'hFFFF));
    return int'($urandom_range(0, 16'hFFFF));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state with busy inputs
    step(1, 9'h1AB, 16'h0123, 16'h0456, 16'h0789);
    step(1, 9'h155, 16'h0123, 16'h0456, 16'h0789);
    step(1, 0, 0, 0, 0);
    // R2 indirect and its limits (R7, R8)
    step(0, 0, 16'h0123, 0, 0);
    step(0, 0, 16'h0020, 0, 0);
    step(0, 0, 16'h0021, 0, 0);
    step(0, 0, 16'h0FFF, 0, 0);
    step(0, 0, 16'h1000, 0, 0);
    // R3 / R9 special-purpose window
    step(0, 9'h001, 0, 0, 0);
    step(0, 9'h002, 0, 0, 0);
    step(0, 9'h003, 0, 0, 0);
    step(0, 9'h07F, 0, 0, 0);
    // R4 globals
    step(0, 9'h080, 0, 0, 0);
    step(0, 9'h0FF, 0, 0, 0);
    // R5 data pointer with boundaries (R7, R8)
    step(0, 9'h100, 0, 16'h0FF0, 0);
    step(0, 9'h10F, 0, 16'h0FF0, 0);
    step(0, 9'h110, 0, 16'h0FF0, 0);
    step(0, 9'h17F, 0, 16'hFFF0, 0);
    step(0, 9'h110, 0, 16'h0010, 0);
    step(0, 9'h111, 0, 16'h0010, 0);
    // R6 stack pointer with boundaries (R7, R8)
    step(0, 9'h180, 0, 0, 16'h0200);
    step(0, 9'h1FF, 0, 0, 16'h0F80);
    step(0, 9'h1FF, 0, 0, 16'h0F81);
    step(0, 9'h181, 0, 0, 16'hFFFF);
    step(0, 9'h1A0, 0, 0, 16'h0000);
    // R10: back-to-back mode changes, one per cycle
    phase = "R10/";
    step(0, 9'h1C5, 16'h0300, 16'h0400, 16'h0500);
    step(0, 9'h145, 16'h0300, 16'h0400, 16'h0500);
    step(0, 9'h0C5, 16'h0300, 16'h0400, 16'h0500);
    step(0, 9'h045, 16'h0300, 16'h0400, 16'h0500);
    step(0, 0,      16'h0300, 16'h0400, 16'h0500);
    // R1 mid-run reset
    phase = "";
    step(1, 9'h1C5, 16'h0300, 16'h0400, 16'h0500);
    // random phase
    phase = "rand/";
    for (int i = 0; i < 3000; i++) begin
      step(0, int'($urandom_range(0, 511)), pickPtr(), pickPtr(), pickPtr());
    end
    step(0, 0, 16'h0100, 0, 0);
    @(negedge clk);
    checkFront();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule